// File: doc/BRIEF.md
# Bilinear Sampling Address and Weight Generator

This unit sits in front of a feature buffer that is split into four banks by the parity of the row and column coordinate. Each cycle it may accept one fractional sampling point (x, y). Three cycles later it returns the four word addresses of the point's integer neighbours, one per bank, together with the four bilinear weights. Because the two horizontal neighbours differ in column parity and the two vertical neighbours differ in row parity, the four reads always land in four different banks and can be issued in the same cycle. The weights depend only on the point, so one set serves every channel of the sample.

The shape of the feature map is set by configuration inputs that stay fixed while samples are in flight. These inputs give the map height and width, the channel count, the processing-element group size as a power of two, and a base index that is subtracted from every address. A flag marks points whose upper neighbour falls outside the map. The unit does not clamp such points or act on them in any other way.

Top module: `bli_addr_coef_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_valid` is 0, whatever `in_valid` does.
- R2: A sample accepted with `in_valid` high at a clock edge appears with `out_valid` high exactly three edges later. One sample is accepted on every cycle, bubbles are carried through, and a cycle with `in_valid` low gives a cycle with `out_valid` low.
- R3: `in_x` and `in_y` are unsigned. The upper IW bits hold the integer part and the lower FW bits hold the fraction. The lower neighbour is the integer part, and the upper neighbour is always the integer part plus one, even when the fraction is zero.
- R4: For neighbour column xk and row yk, the address is ((yk div 2) * j + (xk div 2)) * i - base, taken modulo 2^AW. Here j = height div 2, and i = ceil(chan / 2^grp_log2).
- R5: The corner outputs map to neighbours as follows: lb = (floor x, floor y), rb = (floor x + 1, floor y), lt = (floor x, floor y + 1), rt = (floor x + 1, floor y + 1).
- R6: Write dx and dy for the fractions as integers in units of 2^-FW, and ONE = 2^FW. Then w_rt = floor(dx*dy / ONE), w_rb = dx - w_rt, w_lt = dy - w_rt and w_lb = ONE - dx - dy + w_rt. Each weight is FW+1 bits wide.
- R7: For every valid output the four weights sum to exactly ONE.
- R8: A zero x fraction gives w_rb = w_rt = 0. A zero y fraction gives w_lt = w_rt = 0.
- R9: When floor x is even, the rb address equals the lb address. When floor y is even, the lt address equals the lb address.
- R10: `out_oor` is 1 exactly when floor x + 1 >= width or floor y + 1 >= height, and it is delivered with the sample it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present |
| in_x | input | IW+FW | Column coordinate, unsigned fixed point |
| in_y | input | IW+FW | Row coordinate, unsigned fixed point |
| cfg_height | input | HW | Feature-map height |
| cfg_width | input | HW | Feature-map width |
| cfg_chan | input | CW | Channel count |
| cfg_grp_log2 | input | GW | log2 of PE count / 4 |
| cfg_base | input | AW | Base index subtracted from addresses |
| out_valid | output | 1 | Result present |
| out_oor | output | 1 | Upper neighbour outside the map |
| out_addr_lb | output | AW | Address of the left-bottom neighbour |
| out_addr_rb | output | AW | Address of the right-bottom neighbour |
| out_addr_lt | output | AW | Address of the left-top neighbour |
| out_addr_rt | output | AW | Address of the right-top neighbour |
| out_w_lb | output | FW+1 | Weight of the left-bottom neighbour |
| out_w_rb | output | FW+1 | Weight of the right-bottom neighbour |
| out_w_lt | output | FW+1 | Weight of the left-top neighbour |
| out_w_rt | output | FW+1 | Weight of the right-top neighbour |

## Verification
The assertions assume that the configuration inputs hold still while any sample is inside the three-stage pipeline. They also assume a height of at least two and a group exponent that does not exceed the channel field width. The stimulus changes configuration only after four idle cycles have drained the pipeline, and it uses only legal settings. Within those limits the sampling points are drawn at random, including points past the map edge, and are mixed with exact-integer points and idle cycles.

// File: rtl/bli_pkg.sv
package bli_pkg;

  localparam int COORD_INT_W  = 8;
  localparam int COORD_FRAC_W = 7;
  localparam int DIM_W        = 8;
  localparam int CHAN_W       = 8;
  localparam int GRP_W        = 3;
  localparam int ADDR_W       = 16;

  // Corner numbering: bit 0 selects the upper column, bit 1 the upper row.
  typedef enum logic [1:0] {
    CORNER_LB = 2'd0,
    CORNER_RB = 2'd1,
    CORNER_LT = 2'd2,
    CORNER_RT = 2'd3
  } corner_e;

  function automatic logic corner_col_up(corner_e c);
    return (c == CORNER_RB) || (c == CORNER_RT);
  endfunction

  function automatic logic corner_row_up(corner_e c);
    return (c == CORNER_LT) || (c == CORNER_RT);
  endfunction

endpackage

// File: rtl/bli_coord_split.sv
module bli_coord_split #(
  parameter int IW = bli_pkg::COORD_INT_W,
  parameter int FW = bli_pkg::COORD_FRAC_W,
  parameter int HW = bli_pkg::DIM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW+FW-1:0] in_x,
  input  logic [IW+FW-1:0] in_y,
  input  logic [HW-1:0] cfg_width,
  input  logic [HW-1:0] cfg_height,
  output logic [IW-1:0] xf_q,
  output logic [IW-1:0] yf_q,
  output logic [FW-1:0] dx_q,
  output logic [FW-1:0] dy_q,
  output logic          oor_q
);

  localparam int XW = IW + FW;
  localparam int EW = IW + HW + 1;

  // true when floor+1 reaches or passes the limit
  function automatic logic past_edge(logic [IW-1:0] f, logic [HW-1:0] lim);
    return (EW'(f) + EW'(1)) >= EW'(lim);
  endfunction

  logic [IW-1:0] x_int, y_int;
  logic [FW-1:0] x_frac, y_frac;
  logic          edge_hit;

  assign x_int    = in_x[XW-1:FW];
  assign y_int    = in_y[XW-1:FW];
  assign x_frac   = in_x[FW-1:0];
  assign y_frac   = in_y[FW-1:0];
  assign edge_hit = past_edge(x_int, cfg_width) || past_edge(y_int, cfg_height);

  always_ff @(posedge clk) begin
    if (rst) begin
      xf_q  <= '0;
      yf_q  <= '0;
      dx_q  <= '0;
      dy_q  <= '0;
      oor_q <= 1'b0;
    end else begin
      xf_q  <= x_int;
      yf_q  <= y_int;
      dx_q  <= x_frac;
      dy_q  <= y_frac;
      oor_q <= edge_hit;
    end
  end

endmodule

// File: rtl/bli_bank_addr.sv
module bli_bank_addr #(
  parameter int IW = bli_pkg::COORD_INT_W,
  parameter int HW = bli_pkg::DIM_W,
  parameter int CW = bli_pkg::CHAN_W,
  parameter int GW = bli_pkg::GRP_W,
  parameter int AW = bli_pkg::ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IW-1:0]      xf,
  input  logic [IW-1:0]      yf,
  input  logic [HW-1:0]      cfg_height,
  input  logic [CW-1:0]      cfg_chan,
  input  logic [GW-1:0]      cfg_grp_log2,
  input  logic [AW-1:0]      cfg_base,
  output logic [3:0][AW-1:0] addr
);

  import bli_pkg::*;

  localparam int LW  = IW + HW + 1;
  localparam int IDW = CW + 1;
  localparam int PW  = LW + IDW;

  function automatic logic [HW-1:0] row_pitch(logic [HW-1:0] h);
    return h >> 1;
  endfunction

  function automatic logic [IDW-1:0] chan_groups(logic [CW-1:0] c, logic [GW-1:0] g);
    return (IDW'(c) + ((IDW'(1) << g) - IDW'(1))) >> g;
  endfunction

  function automatic logic [LW-1:0] lin_of(logic [IW:0] xc, logic [IW:0] yc,
                                           logic [HW-1:0] jj);
    return LW'(yc >> 1) * LW'(jj) + LW'(xc >> 1);
  endfunction

  logic [HW-1:0]  pitch_j;
  logic [IDW-1:0] stride_i;

  assign pitch_j  = row_pitch(cfg_height);
  assign stride_i = chan_groups(cfg_chan, cfg_grp_log2);

  for (genvar k = 0; k < 4; k++) begin : g_corner
    localparam corner_e CN = corner_e'(k);
    localparam logic    OX = corner_col_up(CN);
    localparam logic    OY = corner_row_up(CN);

    logic [IW:0]   xc, yc;
    logic [LW-1:0] lin;
    logic [AW-1:0] prod_q, addr_q;

    assign xc  = (IW+1)'(xf) + (IW+1)'(OX);
    assign yc  = (IW+1)'(yf) + (IW+1)'(OY);
    assign lin = lin_of(xc, yc, pitch_j);

    always_ff @(posedge clk) begin
      if (rst) begin
        prod_q <= '0;
        addr_q <= '0;
      end else begin
        prod_q <= AW'(PW'(lin) * PW'(stride_i));
        addr_q <= prod_q - cfg_base;
      end
    end

    assign addr[k] = addr_q;
  end

endmodule

// File: rtl/bli_weight_gen.sv
module bli_weight_gen #(
  parameter int FW = bli_pkg::COORD_FRAC_W
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        vld_s1,
  input  logic [FW-1:0] dx,
  input  logic [FW-1:0] dy,
  output logic [FW:0] w_lb,
  output logic [FW:0] w_rb,
  output logic [FW:0] w_lt,
  output logic [FW:0] w_rt
);

  localparam int WW = FW + 1;
  localparam int MW = 2 * FW;
  localparam logic [WW:0] ONE = (WW+1)'(1) << FW;

  function automatic logic [FW-1:0] frac_mul(logic [FW-1:0] a, logic [FW-1:0] b);
    return FW'((MW'(a) * MW'(b)) >> FW);
  endfunction

  function automatic logic [WW-1:0] corner_far(logic [FW-1:0] a, logic [FW-1:0] b,
                                              logic [FW-1:0] g);
    logic [WW:0] t;
    t = ONE - (WW+1)'(a) - (WW+1)'(b) + (WW+1)'(g);
    return t[WW-1:0];
  endfunction

  logic [FW-1:0] dx_q, dy_q, gamma_q;
  logic          v2_q;
  logic          gamma_fits;

  // stage 2: the one shared multiply
  always_ff @(posedge clk) begin
    if (rst) begin
      dx_q    <= '0;
      dy_q    <= '0;
      gamma_q <= '0;
      v2_q    <= 1'b0;
    end else begin
      dx_q    <= dx;
      dy_q    <= dy;
      gamma_q <= frac_mul(dx, dy);
      v2_q    <= vld_s1;
    end
  end

  assign gamma_fits = (gamma_q <= dx_q) && (gamma_q <= dy_q);

  // stage 3: additions and subtractions only
  always_ff @(posedge clk) begin
    if (rst) begin
      w_lb <= '0;
      w_rb <= '0;
      w_lt <= '0;
      w_rt <= '0;
    end else begin
      w_rt <= WW'(gamma_q);
      w_rb <= WW'(dx_q) - WW'(gamma_q);
      w_lt <= WW'(dy_q) - WW'(gamma_q);
      w_lb <= corner_far(dx_q, dy_q, gamma_q);
    end
  end

  // R6
  gamma_bound_chk: assert property (@(posedge clk) disable iff (rst)
    v2_q |-> gamma_fits);

endmodule

// File: rtl/bli_addr_coef_unit.sv
module bli_addr_coef_unit #(
  parameter int IW = bli_pkg::COORD_INT_W,
  parameter int FW = bli_pkg::COORD_FRAC_W,
  parameter int HW = bli_pkg::DIM_W,
  parameter int CW = bli_pkg::CHAN_W,
  parameter int GW = bli_pkg::GRP_W,
  parameter int AW = bli_pkg::ADDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IW+FW-1:0] in_x,
  input  logic [IW+FW-1:0] in_y,
  input  logic [HW-1:0]    cfg_height,
  input  logic [HW-1:0]    cfg_width,
  input  logic [CW-1:0]    cfg_chan,
  input  logic [GW-1:0]    cfg_grp_log2,
  input  logic [AW-1:0]    cfg_base,
  output logic             out_valid,
  output logic             out_oor,
  output logic [AW-1:0]    out_addr_lb,
  output logic [AW-1:0]    out_addr_rb,
  output logic [AW-1:0]    out_addr_lt,
  output logic [AW-1:0]    out_addr_rt,
  output logic [FW:0]      out_w_lb,
  output logic [FW:0]      out_w_rb,
  output logic [FW:0]      out_w_lt,
  output logic [FW:0]      out_w_rt
);

  import bli_pkg::*;

  localparam int SW = FW + 3;
  localparam logic [SW-1:0] ONE_SUM = SW'(1) << FW;

  logic [IW-1:0]      xf_s1, yf_s1;
  logic [FW-1:0]      dx_s1, dy_s1;
  logic               oor_s1;
  logic [2:0]         vld_pipe;
  logic [1:0]         oor_pipe;
  logic [3:0][AW-1:0] addr_all;
  logic [SW-1:0]      w_sum;

  bli_coord_split #(.IW(IW), .FW(FW), .HW(HW)) u_split (
    .clk        (clk),
    .rst        (rst),
    .in_x       (in_x),
    .in_y       (in_y),
    .cfg_width  (cfg_width),
    .cfg_height (cfg_height),
    .xf_q       (xf_s1),
    .yf_q       (yf_s1),
    .dx_q       (dx_s1),
    .dy_q       (dy_s1),
    .oor_q      (oor_s1)
  );

  bli_bank_addr #(.IW(IW), .HW(HW), .CW(CW), .GW(GW), .AW(AW)) u_addr (
    .clk          (clk),
    .rst          (rst),
    .xf           (xf_s1),
    .yf           (yf_s1),
    .cfg_height   (cfg_height),
    .cfg_chan     (cfg_chan),
    .cfg_grp_log2 (cfg_grp_log2),
    .cfg_base     (cfg_base),
    .addr         (addr_all)
  );

  bli_weight_gen #(.FW(FW)) u_wgt (
    .clk    (clk),
    .rst    (rst),
    .vld_s1 (vld_pipe[0]),
    .dx     (dx_s1),
    .dy     (dy_s1),
    .w_lb   (out_w_lb),
    .w_rb   (out_w_rb),
    .w_lt   (out_w_lt),
    .w_rt   (out_w_rt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_pipe <= '0;
      oor_pipe <= '0;
    end else begin
      vld_pipe <= {vld_pipe[1:0], in_valid};
      oor_pipe <= {oor_pipe[0], oor_s1};
    end
  end

  assign out_valid   = vld_pipe[2];
  assign out_oor     = oor_pipe[1];
  assign out_addr_lb = addr_all[CORNER_LB];
  assign out_addr_rb = addr_all[CORNER_RB];
  assign out_addr_lt = addr_all[CORNER_LT];
  assign out_addr_rt = addr_all[CORNER_RT];

  assign w_sum = SW'(out_w_lb) + SW'(out_w_rb) + SW'(out_w_lt) + SW'(out_w_rt);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##2 out_valid);

  // R7
  weight_sum_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (w_sum == ONE_SUM));

  // R8
  flat_x_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_x[FW-1:0] == '0)) |=> ##2 (out_w_rb == '0 && out_w_rt == '0));

  // R9
  even_col_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_x[FW]) |=> ##2 (out_addr_rb == out_addr_lb));

  // R9
  even_row_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_y[FW]) |=> ##2 (out_addr_lt == out_addr_lb));

endmodule

// File: tb/bli_addr_coef_unit_test.sv
module bli_addr_coef_unit_test;

  localparam int IW = 8;
  localparam int FW = 7;
  localparam int HW = 8;
  localparam int CW = 8;
  localparam int GW = 3;
  localparam int AW = 16;
  localparam int ONE = 1 << FW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [IW+FW-1:0] in_x = '0, in_y = '0;
  logic [HW-1:0] cfg_height = '0, cfg_width = '0;
  logic [CW-1:0] cfg_chan = '0;
  logic [GW-1:0] cfg_grp_log2 = '0;
  logic [AW-1:0] cfg_base = '0;
  logic out_valid, out_oor;
  logic [AW-1:0] out_addr_lb, out_addr_rb, out_addr_lt, out_addr_rt;
  logic [FW:0] out_w_lb, out_w_rb, out_w_lt, out_w_rt;

  int total = 0;
  int bad = 0;

  typedef struct {
    bit v;
    bit oor;
    int xi;
    int yi;
    int fx;
    int fy;
    int a[4];
    int w[4];
  } exp_t;

  exp_t q[$];

  bli_addr_coef_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .cfg_height(cfg_height), .cfg_width(cfg_width), .cfg_chan(cfg_chan),
    .cfg_grp_log2(cfg_grp_log2), .cfg_base(cfg_base),
    .out_valid(out_valid), .out_oor(out_oor),
    .out_addr_lb(out_addr_lb), .out_addr_rb(out_addr_rb),
    .out_addr_lt(out_addr_lt), .out_addr_rt(out_addr_rt),
    .out_w_lb(out_w_lb), .out_w_rb(out_w_rb), .out_w_lt(out_w_lt), .out_w_rt(out_w_rt)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input bit v, input int x, input int y);
    exp_t e;
    int jj, ii, g;
    e.v = v;
    e.xi = x >> FW;
    e.yi = y >> FW;
    e.fx = x & (ONE - 1);
    e.fy = y & (ONE - 1);
    jj = int'(cfg_height) / 2;
    ii = (int'(cfg_chan) + (1 << cfg_grp_log2) - 1) >> cfg_grp_log2;
    for (int k = 0; k < 4; k++) begin
      int xk = e.xi + (k % 2);
      int yk = e.yi + (k / 2);
      e.a[k] = (((yk / 2) * jj + (xk / 2)) * ii - int'(cfg_base)) & ((1 << AW) - 1);
    end
    g = (e.fx * e.fy) / ONE;
    e.w[0] = ((ONE - e.fx) * (ONE - e.fy)) / ONE;
    e.w[1] = e.fx - g;
    e.w[2] = e.fy - g;
    e.w[3] = g;
    e.oor = (e.xi + 1 >= int'(cfg_width)) || (e.yi + 1 >= int'(cfg_height));
    return e;
  endfunction

  task automatic compare(input exp_t e);
    int aa[4];
    int ww[4];
    aa = '{int'(out_addr_lb), int'(out_addr_rb), int'(out_addr_lt), int'(out_addr_rt)};
    ww = '{int'(out_w_lb), int'(out_w_rb), int'(out_w_lt), int'(out_w_rt)};
    chk(out_valid == e.v, "R2", "out_valid", out_valid, e.v);
    if (e.v && out_valid) begin
      chk(out_oor == e.oor, "R10", "out_oor", out_oor, e.oor);
      chk(aa[0] == e.a[0], "R4", "addr_lb", aa[0], e.a[0]);
      chk(aa[1] == e.a[1], "R3 R5", "addr_rb", aa[1], e.a[1]);
      chk(aa[2] == e.a[2], "R3 R5", "addr_lt", aa[2], e.a[2]);
      chk(aa[3] == e.a[3], "R3 R5", "addr_rt", aa[3], e.a[3]);
      for (int k = 0; k < 4; k++)
        chk(ww[k] == e.w[k], "R6", $sformatf("weight%0d", k), ww[k], e.w[k]);
      chk(ww[0] + ww[1] + ww[2] + ww[3] == ONE, "R7", "weight sum",
          ww[0] + ww[1] + ww[2] + ww[3], ONE);
      if (e.fx == 0)
        chk(ww[1] == 0 && ww[3] == 0, "R8", "right weights", ww[1] + ww[3], 0);
      if (e.fy == 0)
        chk(ww[2] == 0 && ww[3] == 0, "R8", "top weights", ww[2] + ww[3], 0);
      if (e.xi % 2 == 0)
        chk(aa[1] == aa[0], "R9", "even column rb", aa[1], aa[0]);
      if (e.yi % 2 == 0)
        chk(aa[2] == aa[0], "R9", "even row lt", aa[2], aa[0]);
    end
  endtask

  task automatic step(input bit v, input int x, input int y);
    @(negedge clk);
    compare(q.pop_front());
    in_valid = v;
    in_x = (IW+FW)'(x);
    in_y = (IW+FW)'(y);
    q.push_back(model(v, x, y));
  endtask

  task automatic drain();
    for (int n = 0; n < 4; n++) step(1'b0, 0, 0);
  endtask

  task automatic random_run(input int n, input int xmax, input int ymax);
    for (int s = 0; s < n; s++) begin
      bit v = ($urandom % 4) != 0;
      int x = (($urandom % xmax) << FW) | ($urandom % ONE);
      int y = (($urandom % ymax) << FW) | ($urandom % ONE);
      step(v, x, y);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfg_height = 8'd32;
    cfg_width = 8'd32;
    cfg_chan = 8'd16;
    cfg_grp_log2 = 3'd2;
    cfg_base = '0;
    rst = 1'b1;
    in_valid = 1'b1;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    end
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    for (int n = 0; n < 3; n++) q.push_back(model(1'b0, 0, 0));

    // directed points in units of 1/128
    step(1'b1, 3 * ONE, 5 * ONE);          // exact integer point
    step(1'b1, 4 * ONE + 64, 6 * ONE + 32);
    step(1'b1, 7 * ONE + 96, 9 * ONE + 64);
    step(1'b0, 0, 0);
    step(1'b1, 30 * ONE + 127, 2 * ONE);
    step(1'b1, 31 * ONE + 64, 0);          // x past the edge
    step(1'b1, 0, 31 * ONE);               // y past the edge
    step(1'b1, 0, 0);
    step(1'b1, 1 * ONE + 127, 1 * ONE + 127);
    random_run(40, 36, 36);
    drain();

    cfg_height = 8'd20;
    cfg_width = 8'd24;
    cfg_chan = 8'd10;
    cfg_grp_log2 = 3'd1;
    cfg_base = 16'd7;
    step(1'b1, 0, 0);                      // base makes the address wrap
    random_run(40, 28, 24);
    drain();

    cfg_height = 8'd255;
    cfg_width = 8'd255;
    cfg_chan = 8'd3;
    cfg_grp_log2 = 3'd3;
    cfg_base = 16'hFFF0;
    step(1'b1, 255 * ONE + 127, 255 * ONE + 127);
    step(1'b1, 254 * ONE, 253 * ONE + 1);
    random_run(40, 256, 256);
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule